// File: doc/BRIEF.md
# Leaky Bucket Activity Alarm

This block judges whether one input clock is healthy by keeping a score of its irregularities. A separate detector pulses `irregular` whenever it sees something wrong with the clock. A free-running strobe, `tick`, marks the end of each eighth-of-a-second interval. Any interval that saw at least one irregularity adds one unit to a bounded accumulator. Intervals without trouble drain it slowly, at a rate set by a power-of-two divider.

When the accumulator climbs to the upper threshold, the activity alarm is raised and the clock is marked not valid. The alarm is held until the accumulator drains down to the lower threshold. This hysteresis keeps a marginal clock from toggling the alarm on and off.

Four parameter sets are presented in parallel, and `cfgSel` picks the one in force. Each set holds an upper threshold, a lower threshold, a bucket size and a decay exponent. A set that breaks the ordering size > upper > lower is flagged on `configError`. While that flag is up, the accumulator and the alarm are frozen.

Top module: `leaky_bucket_alarm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `level` to 0, `activityAlarm` to 0 and `clockValid` to 1, at any time.
- R2: On a cycle with `tick` high, if at least one `irregular` pulse occurred since the previous tick, `level` rises by exactly one. This includes a pulse in the same cycle as `tick`. Several pulses in one interval still add only one.
- R3: With decay code D (0..3), a leak of one unit happens on the 2^D-th consecutive interval with no irregularity, and the interval count then restarts. This gives roughly 8, 4, 2 or 1 units per second.
- R4: A leak never takes `level` below 0.
- R5: Once `level` reaches the upper threshold U, `activityAlarm` is 1 and `clockValid` is 0. From an empty bucket this takes U filled intervals.
- R6: A fill never takes `level` above the bucket size S. A fill at or above S leaves `level` at S.
- R7: The alarm stays set while `level` is above the lower threshold L, and clears once `level` is at or below L. From a full bucket this takes 2^D*(S-L) empty intervals.
- R8: No leak happens in an interval that contains a fill, and every fill restarts the decay interval count.
- R9: `configError` is 1 exactly when the selected set breaks S > U > L. While it is 1, `level` and `activityAlarm` hold their values.
- R10: `cfgSel` = i selects set i, whose fields sit at bits [i*LVL_W +: LVL_W] of the threshold and size buses and at bits [i*DEC_W +: DEC_W] of `cfgDecay`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe closing each 1/8 s interval |
| irregular | input | 1 | One-cycle strobe per detected clock irregularity |
| cfgSel | input | 2 | Index of the active parameter set |
| cfgUpper | input | 4*LVL_W | Upper (declare) thresholds, one per set |
| cfgLower | input | 4*LVL_W | Lower (clear) thresholds, one per set |
| cfgSize | input | 4*LVL_W | Bucket sizes, one per set |
| cfgDecay | input | 4*DEC_W | Decay exponents, one per set |
| level | output | LVL_W | Current accumulator value |
| activityAlarm | output | 1 | Activity alarm |
| clockValid | output | 1 | High when the clock is judged usable |
| configError | output | 1 | Selected set breaks S > U > L |

## Verification
`level`, `activityAlarm` and `clockValid` all change at the clock edge that samples `tick` high, so each interval's result is due one edge after the tick is driven. `configError` is combinational from `cfgSel` and is due as soon as the select settles. The bench drives inputs on falling edges and lowers `tick` on the falling edge after that update edge. It samples there, half a cycle after the update and well clear of the next edge. Declare and clear timing is checked by counting intervals against U and 2^D*(S-L), and by checking the values one interval before each transition.

// File: rtl/lb_pkg.sv
package lb_pkg;
  // Strobes from control to datapath; at most one of fill/leak per cycle.
  typedef struct packed {
    logic fill;
    logic leak;
    logic hold;
  } lbStrobes_t;
endpackage

// File: rtl/lb_cfg_select.sv
module lb_cfg_select #(
  parameter int LVL_W = 8,
  parameter int DEC_W = 2,
  parameter int NUM_SETS = 4,
  localparam int SEL_W = $clog2(NUM_SETS)
) (
  input  logic [SEL_W-1:0]          cfgSel,
  input  logic [NUM_SETS*LVL_W-1:0] cfgUpper,
  input  logic [NUM_SETS*LVL_W-1:0] cfgLower,
  input  logic [NUM_SETS*LVL_W-1:0] cfgSize,
  input  logic [NUM_SETS*DEC_W-1:0] cfgDecay,
  output logic [LVL_W-1:0]          upper,
  output logic [LVL_W-1:0]          lower,
  output logic [LVL_W-1:0]          size,
  output logic [DEC_W-1:0]          decay,
  output logic                      cfgError
);
  logic [LVL_W-1:0] upperArr [NUM_SETS];
  logic [LVL_W-1:0] lowerArr [NUM_SETS];
  logic [LVL_W-1:0] sizeArr  [NUM_SETS];
  logic [DEC_W-1:0] decayArr [NUM_SETS];

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_unpack
    assign upperArr[i] = cfgUpper[i*LVL_W +: LVL_W];
    assign lowerArr[i] = cfgLower[i*LVL_W +: LVL_W];
    assign sizeArr[i]  = cfgSize[i*LVL_W +: LVL_W];
    assign decayArr[i] = cfgDecay[i*DEC_W +: DEC_W];
  end

  always_comb begin
    upper = upperArr[cfgSel];
    lower = lowerArr[cfgSel];
    size  = sizeArr[cfgSel];
    decay = decayArr[cfgSel];
    // Legal set needs size > upper > lower.
    cfgError = !((size > upper) && (upper > lower));
  end
endmodule

// File: rtl/lb_control.sv
module lb_control
  import lb_pkg::*;
#(
  parameter int DEC_W = 2,
  localparam int DIV_W = (1 << DEC_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             irregular,
  input  logic [DEC_W-1:0] decay,
  input  logic             cfgError,
  output lbStrobes_t       strobes
);
  logic             fillSeen;
  logic             intervalFill;
  logic [DIV_W-1:0] emptyCnt;
  logic [DIV_W-1:0] decayLimit;
  logic             leakNow;

  assign intervalFill = fillSeen | irregular;
  assign decayLimit   = DIV_W'((32'd1 << decay) - 32'd1);
  assign leakNow      = tick && !intervalFill && !cfgError && (emptyCnt >= decayLimit);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillSeen <= 1'b0;
      emptyCnt <= '0;
    end else begin
      if (tick) fillSeen <= 1'b0;
      else if (irregular) fillSeen <= 1'b1;
      if (tick) begin
        if (cfgError || intervalFill || leakNow) emptyCnt <= '0;
        else emptyCnt <= emptyCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.fill = tick && intervalFill && !cfgError;
    strobes.leak = leakNow;
    strobes.hold = cfgError;
  end

  // R8: an irregularity on the tick cycle always blocks the leak
  a_r8_fill_blocks_leak: assert property (@(posedge clk) disable iff (rst)
    (tick && irregular) |-> !strobes.leak);
  // R3: fill and leak are exclusive
  a_r3_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.fill, strobes.leak}));
  // R9: error blocks both actions
  a_r9_no_action_on_error: assert property (@(posedge clk) disable iff (rst)
    cfgError |-> !(strobes.fill || strobes.leak));
endmodule

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  lbStrobes_t       strobes,
  input  logic [LVL_W-1:0] upper,
  input  logic [LVL_W-1:0] lower,
  input  logic [LVL_W-1:0] size,
  output logic [LVL_W-1:0] levelQ,
  output logic             alarmQ
);
  logic [LVL_W-1:0] nextLevel;
  logic             nextAlarm;

  always_comb begin
    nextLevel = levelQ;
    if (strobes.hold) nextLevel = levelQ;
    else if (strobes.fill) nextLevel = (levelQ >= size) ? size : levelQ + 1'b1;
    else if (strobes.leak) nextLevel = (levelQ == '0) ? '0 : levelQ - 1'b1;

    nextAlarm = alarmQ;
    if (!strobes.hold) begin
      if (nextLevel >= upper) nextAlarm = 1'b1;
      else if (nextLevel <= lower) nextAlarm = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= '0;
      alarmQ <= 1'b0;
    end else begin
      levelQ <= nextLevel;
      alarmQ <= nextAlarm;
    end
  end

  // R2: the level never climbs more than one step per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, levelQ} <= {1'b0, $past(levelQ)} + 1'b1));
  // R4: a leak on an empty bucket leaves it empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (strobes.leak && levelQ == '0) |=> levelQ == '0);
  // R6: a fill ends at or below the size
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (strobes.fill && !strobes.hold) |=> levelQ <= $past(size));
  // R9: frozen state under a bad configuration
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    strobes.hold |=> ($stable(levelQ) && $stable(alarmQ)));
  // R5: alarm rises only at or above the upper threshold
  a_r5_declare: assert property (@(posedge clk) disable iff (rst)
    $rose(alarmQ) |-> levelQ >= $past(upper));
  // R7: alarm drops only at or below the lower threshold
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    ($fell(alarmQ) && !$past(rst)) |-> levelQ <= $past(lower));
endmodule

// File: rtl/leaky_bucket_alarm.sv
module leaky_bucket_alarm
  import lb_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int DEC_W = 2,
  parameter int NUM_SETS = 4,
  localparam int SEL_W = $clog2(NUM_SETS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      irregular,
  input  logic [SEL_W-1:0]          cfgSel,
  input  logic [NUM_SETS*LVL_W-1:0] cfgUpper,
  input  logic [NUM_SETS*LVL_W-1:0] cfgLower,
  input  logic [NUM_SETS*LVL_W-1:0] cfgSize,
  input  logic [NUM_SETS*DEC_W-1:0] cfgDecay,
  output logic [LVL_W-1:0]          level,
  output logic                      activityAlarm,
  output logic                      clockValid,
  output logic                      configError
);
  logic [LVL_W-1:0] upper, lower, size;
  logic [DEC_W-1:0] decay;
  lbStrobes_t       strobes;

  lb_cfg_select #(.LVL_W(LVL_W), .DEC_W(DEC_W), .NUM_SETS(NUM_SETS)) cfg_i (
    .cfgSel(cfgSel), .cfgUpper(cfgUpper), .cfgLower(cfgLower),
    .cfgSize(cfgSize), .cfgDecay(cfgDecay),
    .upper(upper), .lower(lower), .size(size), .decay(decay),
    .cfgError(configError)
  );

  lb_control #(.DEC_W(DEC_W)) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick), .irregular(irregular),
    .decay(decay), .cfgError(configError), .strobes(strobes)
  );

  lb_datapath #(.LVL_W(LVL_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .upper(upper), .lower(lower), .size(size),
    .levelQ(level), .alarmQ(activityAlarm)
  );

  assign clockValid = !activityAlarm;
endmodule

// File: tb/leaky_bucket_alarm_tb_top.sv
module leaky_bucket_alarm_tb_top;
  localparam int LVL_W = 8;
  localparam int DEC_W = 2;

  logic clk = 1'b0;
  logic rst, tick, irregular;
  logic [1:0] cfgSel;
  logic [4*LVL_W-1:0] cfgUpper, cfgLower, cfgSize;
  logic [4*DEC_W-1:0] cfgDecay;
  logic [LVL_W-1:0] level;
  logic activityAlarm, clockValid, configError;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  leaky_bucket_alarm #(.LVL_W(LVL_W), .DEC_W(DEC_W), .NUM_SETS(4)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .irregular(irregular), .cfgSel(cfgSel),
    .cfgUpper(cfgUpper), .cfgLower(cfgLower), .cfgSize(cfgSize), .cfgDecay(cfgDecay),
    .level(level), .activityAlarm(activityAlarm), .clockValid(clockValid),
    .configError(configError)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One interval: `pulses` irregularities, then the tick (optionally with one more
  // irregularity on the tick cycle). Returns on the falling edge after the update edge.
  task automatic interval(input int pulses, input bit onTick);
    for (int p = 0; p < pulses; p++) begin
      @(negedge clk) irregular = 1'b1;
      @(negedge clk) irregular = 1'b0;
    end
    @(negedge clk) begin tick = 1'b1; irregular = onTick; end
    @(negedge clk) begin tick = 1'b0; irregular = 1'b0; end
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset level", level, 0);
    check("R1 reset alarm", activityAlarm, 0);
    check("R1 reset valid", clockValid, 1);
    check("R9 legal set0 error", configError, 0);
  endtask

  // set0: U=8 L=1 S=10 D=0
  task automatic testDeclare();
    cfgSel = 2'd0;
    for (int i = 0; i < 7; i++) interval(1, 1'b0);
    check("R5 U-1 level", level, 7);
    check("R5 no alarm before U", activityAlarm, 0);
    interval(1, 1'b0);
    check("R2 U intervals level", level, 8);
    check("R5 alarm at U", activityAlarm, 1);
    check("R5 valid low", clockValid, 0);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 5; i++) interval(1, 1'b0);
    check("R6 saturate at S", level, 10);
  endtask

  task automatic testClear();
    for (int i = 0; i < 8; i++) interval(0, 1'b0);
    check("R7 hysteresis level", level, 2);
    check("R7 alarm held above L", activityAlarm, 1);
    interval(0, 1'b0);  // 9th = 2^0*(10-1)
    check("R7 clear level", level, 1);
    check("R7 alarm cleared at L", activityAlarm, 0);
    check("R7 valid back", clockValid, 1);
  endtask

  task automatic testFloor();
    for (int i = 0; i < 3; i++) interval(0, 1'b0);
    check("R4 floor zero", level, 0);
  endtask

  // set1: U=5 L=2 S=6 D=2
  task automatic testDecay();
    doReset();
    cfgSel = 2'd1;
    interval(3, 1'b0);
    check("R2 many pulses one unit", level, 1);
    interval(0, 1'b1);
    check("R2 pulse on tick counts", level, 2);
    interval(1, 1'b0);
    for (int i = 0; i < 3; i++) interval(0, 1'b0);
    check("R3 no leak before 2^D", level, 3);
    interval(0, 1'b0);
    check("R3 leak at 2^D", level, 2);
    for (int i = 0; i < 3; i++) interval(0, 1'b0);
    interval(1, 1'b0);
    check("R8 fill blocks leak", level, 3);
    for (int i = 0; i < 3; i++) interval(0, 1'b0);
    check("R8 divider restarted", level, 3);
    interval(0, 1'b0);
    check("R8 leak after restart", level, 2);
  endtask

  // set2: U=5 L=5 S=9 -> illegal
  task automatic testCfgError();
    @(negedge clk) cfgSel = 2'd2;
    #1 check("R9 error flagged", configError, 1);
    interval(1, 1'b0);
    interval(1, 1'b0);
    check("R9 fill frozen", level, 2);
    for (int i = 0; i < 4; i++) interval(0, 1'b0);
    check("R9 leak frozen", level, 2);
    @(negedge clk) cfgSel = 2'd1;
    #1 check("R10 legal set1 selected", configError, 0);
  endtask

  // set3: U=3 L=0 S=4 D=1
  task automatic testSet3();
    doReset();
    cfgSel = 2'd3;
    for (int i = 0; i < 3; i++) interval(1, 1'b0);
    check("R10 set3 alarm at U=3", activityAlarm, 1);
    interval(0, 1'b0);
    check("R3 D=1 first empty", level, 3);
    interval(0, 1'b0);
    check("R3 D=1 leak", level, 2);
    for (int i = 0; i < 3; i++) interval(0, 1'b0);
    check("R7 alarm above L=0", activityAlarm, 1);
    interval(0, 1'b0);  // 6th = 2^1*(3-0)
    check("R7 clear at zero", level, 0);
    check("R7 alarm clear D=1", activityAlarm, 0);
  endtask

  task automatic testSyncReset();
    cfgSel = 2'd0;
    for (int i = 0; i < 8; i++) interval(1, 1'b0);
    check("R5 alarm before reset", activityAlarm, 1);
    doReset();
    check("R1 sync reset level", level, 0);
    check("R1 sync reset alarm", activityAlarm, 0);
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; irregular = 1'b0; cfgSel = 2'd0;
    cfgUpper = {8'd3, 8'd5, 8'd5, 8'd8};
    cfgLower = {8'd0, 8'd5, 8'd2, 8'd1};
    cfgSize  = {8'd4, 8'd9, 8'd6, 8'd10};
    cfgDecay = {2'd1, 2'd0, 2'd2, 2'd0};
    repeat (3) @(negedge clk);
    testReset();
    testDeclare();
    testSaturate();
    testClear();
    testFloor();
    testDecay();
    testCfgError();
    testSet3();
    testSyncReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule